// File: doc/BRIEF.md
# Audio Transmitter Control and Interrupt Register

This block is the single control and status word of a serial digital audio transmitter. Software reaches it through a plain register bus with an address, a write strobe, write data and read data. The transmitter logic reports three events as single-cycle strobes: the last of a 96-bit user-data block has been sent, the sample buffer has run empty, and the sample count has reached the programmed repetition count. Each strobe latches a pending flag. Each flag has its own enable bit, and the enabled pending flags are ORed into one registered interrupt line.

Software clears a pending flag by writing 1 to its position. Writing 0 there leaves it alone. If a strobe and a clear land in the same cycle, the strobe wins, so no event is lost.

The same word also holds static mode settings for the transmitter: where user data is taken from, the master-clock-to-sample-rate ratio and the byte-swap mode. It also has a software reset bit. Writing 1 to that bit produces a pulse one cycle long and nothing more. The pulse goes to the transmitter's synchronous reset, which only acts while the master clock runs.

Top module: `atx_ctrl_reg`

## Requirements
- R1: After the asynchronous reset, every field reads as 0, and `irq_o` and `soft_rst_o` are 0.
- R2: A write to the register address loads the mode and enable fields in the cycle of the write, and they read back unchanged. The fields are: bit 12 user-data source (0 = separate user-data registers, 1 = bit 23 of each sample), bits 4:3 clock ratio (00 = 256x, 01 = 384x), bits 2:1 byte-swap mode (10 = three-byte swap, 11 = two-byte swap), and the enables at bits 10, 8 and 6. The outputs `user_in_pcm_o`, `mclk_ratio_o` and `swap_mode_o` follow these fields.
- R3: A strobe on `ev_user_done_i`, `ev_buf_empty_i` or `ev_stream_end_i` sets the pending flag at bit 11, 9 or 7 respectively. The flag reads 1 from the next cycle on.
- R4: Writing 1 to a pending bit clears it. Writing 0 to it leaves it unchanged.
- R5: When a strobe and a write of 1 to the same pending bit occur in one cycle, the flag ends up set.
- R6: A pending flag whose enable bit is 0 does not raise `irq_o`, and the flag stays pending.
- R7: `irq_o` equals the OR over the three sources of (pending AND enable), delayed by one register stage.
- R8: Writing 1 to bit 5 drives `soft_rst_o` high for exactly one cycle. Bit 5 always reads 0, and the reset pulse changes no other field.
- R9: Bits 0 and 13 and up read 0 and ignore writes. Reads from any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| ev_user_done_i | input | 1 | Strobe: 96-bit user block sent |
| ev_buf_empty_i | input | 1 | Strobe: sample buffer empty |
| ev_stream_end_i | input | 1 | Strobe: repetition count reached |
| irq_o | output | 1 | Registered combined interrupt |
| soft_rst_o | output | 1 | One-cycle transmitter reset pulse |
| user_in_pcm_o | output | 1 | User-data source select |
| mclk_ratio_o | output | 2 | Master clock ratio select |
| swap_mode_o | output | 2 | Byte-swap mode select |

## Verification
The flags are exercised in several ways: strobes on their own while the flag is masked, strobes after the enable is set, all three strobes in one cycle, and strobes that coincide with a clearing write, both on a flag that is already set and on one that is clear. Together these separate set-priority, the clear rule and the masking rule. Writes of all ones, writes to a foreign address and write-0-to-pending patterns show whether unused bits, address decoding and the no-effect case leak into state. The interrupt line is sampled in the cycle right after each state change and again one cycle later, which exposes a missing or extra register stage.

// File: rtl/atx_ctrl_pkg.sv
package atx_ctrl_pkg;

  localparam int N_SRC     = 3;
  localparam int BIT_UMODE = 12;
  localparam int BIT_SRST  = 5;
  localparam int RATIO_LO  = 3;
  localparam int SWAP_LO   = 1;
  localparam int TOP_BIT   = 12;

  typedef enum int {
    SRC_USER = 0,
    SRC_BUF  = 1,
    SRC_END  = 2
  } src_e;

  typedef enum logic [1:0] {
    RATIO_256 = 2'b00,
    RATIO_384 = 2'b01,
    RATIO_X2  = 2'b10,
    RATIO_X3  = 2'b11
  } ratio_e;

  typedef enum logic [1:0] {
    SWAP_M0  = 2'b00,
    SWAP_M1  = 2'b01,
    SWAP_3B  = 2'b10,
    SWAP_2B  = 2'b11
  } swap_e;

  typedef struct packed {
    logic   umode;
    ratio_e ratio;
    swap_e  swap;
  } mode_t;

  // pending/enable pairs sit in descending pairs from bit 11
  function automatic int pend_bit(input int idx);
    return 11 - 2 * idx;
  endfunction

  function automatic int en_bit(input int idx);
    return 10 - 2 * idx;
  endfunction

endpackage

// File: rtl/atx_irq_flag.sv
module atx_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic clr_bit_i,
  input  logic en_bit_i,
  output logic pend_o,
  output logic en_o
);

  logic pend_q, pend_d;
  logic en_q, en_d;
  logic pend_ce;

  always_comb begin
    pend_ce = set_i | (wr_i & clr_bit_i);
    pend_d  = pend_q;
    if (wr_i && clr_bit_i) pend_d = 1'b0;
    // hardware set overrides a coincident software clear
    if (set_i) pend_d = 1'b1;
    en_d = en_q;
    if (wr_i) en_d = en_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (wr_i) begin
      en_q <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/atx_mode_regs.sv
module atx_mode_regs
  import atx_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       umode_i,
  input  logic [1:0] ratio_i,
  input  logic [1:0] swap_i,
  input  logic       srst_i,
  output mode_t      mode_o,
  output logic       srst_o
);

  mode_t mode_q, mode_d;
  logic  srst_q, srst_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_i) begin
      mode_d.umode = umode_i;
      mode_d.ratio = ratio_e'(ratio_i);
      mode_d.swap  = swap_e'(swap_i);
    end
    // pulse lasts one cycle: next value depends only on this cycle's write
    srst_d = wr_i & srst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '{umode: 1'b0, ratio: RATIO_256, swap: SWAP_M0};
    end else if (wr_i) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_d;
    end
  end

  assign mode_o = mode_q;
  assign srst_o = srst_q;

endmodule

// File: rtl/atx_rd_mux.sv
module atx_rd_mux
  import atx_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              hit_i,
  input  mode_t             mode_i,
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_SRC-1:0]  en_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      rdata_o[BIT_UMODE]             = mode_i.umode;
      rdata_o[RATIO_LO+1:RATIO_LO]   = mode_i.ratio;
      rdata_o[SWAP_LO+1:SWAP_LO]     = mode_i.swap;
      for (int i = 0; i < N_SRC; i++) begin
        rdata_o[pend_bit(i)] = pend_i[i];
        rdata_o[en_bit(i)]   = en_i[i];
      end
    end
  end

endmodule

// File: rtl/atx_ctrl_reg.sv
module atx_ctrl_reg
  import atx_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REG_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ev_user_done_i,
  input  logic              ev_buf_empty_i,
  input  logic              ev_stream_end_i,
  output logic              irq_o,
  output logic              soft_rst_o,
  output logic              user_in_pcm_o,
  output logic [1:0]        mclk_ratio_o,
  output logic [1:0]        swap_mode_o
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic             addr_hit;
  logic             wr_hit;
  logic [N_SRC-1:0] ev_vec;
  logic [N_SRC-1:0] pend_vec;
  logic [N_SRC-1:0] en_vec;
  mode_t            mode;
  logic             irq_q, irq_d;
  logic             unused_wdata;

  assign addr_hit = (bus_addr_i == HIT_ADDR);
  assign wr_hit   = bus_wr_i & addr_hit;

  always_comb begin
    ev_vec           = '0;
    ev_vec[SRC_USER] = ev_user_done_i;
    ev_vec[SRC_BUF]  = ev_buf_empty_i;
    ev_vec[SRC_END]  = ev_stream_end_i;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    atx_irq_flag u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (ev_vec[g]),
      .wr_i      (wr_hit),
      .clr_bit_i (bus_wdata_i[pend_bit(g)]),
      .en_bit_i  (bus_wdata_i[en_bit(g)]),
      .pend_o    (pend_vec[g]),
      .en_o      (en_vec[g])
    );
  end

  atx_mode_regs u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_hit),
    .umode_i (bus_wdata_i[BIT_UMODE]),
    .ratio_i (bus_wdata_i[RATIO_LO+1:RATIO_LO]),
    .swap_i  (bus_wdata_i[SWAP_LO+1:SWAP_LO]),
    .srst_i  (bus_wdata_i[BIT_SRST]),
    .mode_o  (mode),
    .srst_o  (soft_rst_o)
  );

  atx_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .hit_i   (addr_hit),
    .mode_i  (mode),
    .pend_i  (pend_vec),
    .en_i    (en_vec),
    .rdata_o (bus_rdata_o)
  );

  always_comb begin
    irq_d = |(pend_vec & en_vec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o         = irq_q;
  assign user_in_pcm_o = mode.umode;
  assign mclk_ratio_o  = mode.ratio;
  assign swap_mode_o   = mode.swap;
  assign unused_wdata  = ^{bus_wdata_i[DATA_W-1:TOP_BIT+1], bus_wdata_i[0]};

endmodule

// File: rtl/atx_ctrl_reg_chk.sv
module atx_ctrl_reg_chk
  import atx_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  ev_i,
  input logic              wr_hit_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_SRC-1:0]  pend_i,
  input logic [N_SRC-1:0]  en_i,
  input logic              irq_i,
  input logic              srst_i
);

  logic [N_SRC-1:0] clr;
  logic             unused_chk;

  always_comb begin
    clr = '0;
    for (int i = 0; i < N_SRC; i++) clr[i] = wr_hit_i & wdata_i[pend_bit(i)];
  end
  assign unused_chk = ^wdata_i;

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni) (|ev_i) |=> ((pend_i & $past(ev_i)) == $past(ev_i))); // R3
  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni) (!wr_hit_i && ev_i == '0) |=> $stable(pend_i)); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (|(clr & ~ev_i)) |=> ((pend_i & $past(clr & ~ev_i)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) (|(clr & ev_i)) |=> ((pend_i & $past(clr & ev_i)) == $past(clr & ev_i))); // R5
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_hit_i |=> $stable(en_i)); // R2
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) (|(pend_i & en_i)) |=> irq_i); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni) ((pend_i & en_i) == '0) |=> !irq_i); // R6
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) srst_i |=> !srst_i); // R8

endmodule

bind atx_ctrl_reg atx_ctrl_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ev_i     (ev_vec),
  .wr_hit_i (wr_hit),
  .wdata_i  (bus_wdata_i),
  .pend_i   (pend_vec),
  .en_i     (en_vec),
  .irq_i    (irq_o),
  .srst_i   (soft_rst_o)
);

// File: tb/atx_ctrl_reg_bench.sv
module atx_ctrl_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam logic [7:0] A_REG   = 8'h00;
  localparam logic [7:0] A_OTHER = 8'h04;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              wr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              ev_user, ev_buf, ev_end;
  logic              irq, srst, umode;
  logic [1:0]        ratio, swap;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  logic [DATA_W-1:0] exp_q[$];
  string             req_q[$];
  event              sample_ev;

  atx_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(0)) u_atx_ctrl_reg (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .bus_addr_i      (addr),
    .bus_wr_i        (wr),
    .bus_wdata_i     (wdata),
    .bus_rdata_o     (rdata),
    .ev_user_done_i  (ev_user),
    .ev_buf_empty_i  (ev_buf),
    .ev_stream_end_i (ev_end),
    .irq_o           (irq),
    .soft_rst_o      (srst),
    .user_in_pcm_o   (umode),
    .mclk_ratio_o    (ratio),
    .swap_mode_o     (swap)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops an expected read value each time a sample is requested
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() > 0) check(rdata, exp_q.pop_front(), req_q.pop_front());
    end
  end

  // driver: one bus cycle, optional write and event strobes, ends at a negedge
  task automatic bus_cycle(input logic [7:0] a, input logic [31:0] d, input logic w, input logic [2:0] evs);
    @(negedge clk);
    addr = a; wdata = d; wr = w;
    {ev_end, ev_buf, ev_user} = evs;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    {ev_end, ev_buf, ev_user} = 3'b000;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a;
    exp_q.push_back(exp);
    req_q.push_back(req);
    #1 -> sample_ev;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; wdata = '0;
    ev_user = 1'b0; ev_buf = 1'b0; ev_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_REG, 32'h0, "R1 reset readback");
    check(irq, 0, "R1 irq after reset");
    check(srst, 0, "R1 soft reset after reset");

    // R2 mode fields: umode=1, ratio=01 (384x), swap=10
    bus_cycle(A_REG, 32'h0000_100C, 1, 3'b000);
    rd(A_REG, 32'h0000_100C, "R2 mode readback");
    check({umode, ratio, swap}, {27'd0, 1'b1, 2'b01, 2'b10}, "R2 mode outputs");

    // R9 unused bits and foreign address
    bus_cycle(A_REG, 32'hFFFF_E001 | 32'h100C, 1, 3'b000);
    step();
    rd(A_REG, 32'h0000_100C, "R9 unused bits ignored");
    bus_cycle(A_OTHER, 32'h0000_0000, 1, 3'b000);
    rd(A_REG, 32'h0000_100C, "R9 foreign write ignored");
    rd(A_OTHER, 32'h0, "R9 foreign read zero");

    // R3/R6 user event while masked
    bus_cycle(A_REG, 32'h0, 0, 3'b001);
    rd(A_REG, 32'h0000_180C, "R3 user pending set");
    step();
    check(irq, 0, "R6 masked irq stays low");
    rd(A_REG, 32'h0000_180C, "R6 flag stays pending while masked");

    // R4 write 0 to pending keeps it; R7 irq one cycle after enable
    bus_cycle(A_REG, 32'h0000_140C, 1, 3'b000);
    rd(A_REG, 32'h0000_1C0C, "R4 write 0 no effect");
    check(irq, 0, "R7 irq not yet");
    step();
    check(irq, 1, "R7 irq one cycle later");

    // R4 W1C clear; R7 irq falls one cycle later
    bus_cycle(A_REG, 32'h0000_1C0C, 1, 3'b000);
    rd(A_REG, 32'h0000_140C, "R4 user cleared");
    check(irq, 1, "R7 irq still high");
    step();
    check(irq, 0, "R7 irq falls");

    // R3 buffer-empty flag with enables set
    bus_cycle(A_REG, 32'h0000_154C, 1, 3'b000);
    bus_cycle(A_REG, 32'h0, 0, 3'b010);
    rd(A_REG, 32'h0000_174C, "R3 buffer-empty pending");
    step();
    check(irq, 1, "R7 irq from buffer-empty");

    // R5 set wins on already-set flag, then plain clear
    bus_cycle(A_REG, 32'h0000_174C, 1, 3'b010);
    rd(A_REG, 32'h0000_174C, "R5 set wins on set flag");
    bus_cycle(A_REG, 32'h0000_174C, 1, 3'b000);
    rd(A_REG, 32'h0000_154C, "R4 buffer-empty cleared");

    // R5 set wins on clear flag (stream end)
    bus_cycle(A_REG, 32'h0000_15CC, 1, 3'b100);
    rd(A_REG, 32'h0000_15CC, "R5 set wins on clear flag");
    bus_cycle(A_REG, 32'h0000_15CC, 1, 3'b000);
    rd(A_REG, 32'h0000_154C, "R4 stream-end cleared");
    step();
    check(irq, 0, "R7 irq low with no pending");

    // R8 soft reset pulse
    bus_cycle(A_REG, 32'h0000_156C, 1, 3'b000);
    check(srst, 1, "R8 soft reset pulse high");
    rd(A_REG, 32'h0000_154C, "R8 bit reads 0 and fields kept");
    step();
    check(srst, 0, "R8 soft reset self-clears");

    // R3 all three events at once
    bus_cycle(A_REG, 32'h0, 0, 3'b111);
    rd(A_REG, 32'h0000_1FCC, "R3 all pending");
    step();
    check(irq, 1, "R7 irq with all pending");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    rd(A_REG, 32'h0, "R1 reset clears all");
    check(irq, 0, "R1 irq cleared by reset");
    @(negedge clk);
    rst_n = 1'b1;
    step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule